// File: doc/BRIEF.md
# Daisy-Chained Bus Hold Arbiter

This block decides when one device may own a system bus that it shares with several cascaded devices. Any device that has memory traffic pending enables its drive onto a shared, wired-OR hold request line (`hold_oe` is an open-drain style enable, and the line itself is modelled outside the block). The bus owner answers with an acknowledge signal. That acknowledge enters the first device and travels along the cascade.

A device that raised hold and then sees acknowledge keeps the acknowledge for itself. It grants its cycle engine a burst of at most `MAX_BURST` memory cycles. When the last cycle completes, it releases hold and passes acknowledge to the next device. A device that did not request passes acknowledge on with one registered cycle of delay. After a burst, a device stays quiet until the incoming acknowledge has dropped. This keeps a device with continuous traffic from taking every tenure, so with four devices and a burst of four, one tenure carries at most 16 cycles.

The cycle engine reads `grant` and `burst_len`, and it pulses `cyc_done` once for each memory cycle it completes.

Top module: `hold_chain_arb`

## Requirements
- R1: While reset is active, and in the first cycle after it, `hold_oe`, `grant` and `ack_out` are 0.
- R2: When the block is idle, `pend_cnt` is non-zero and `ack_in` is low, `hold_oe` goes to 1 one clock later.
- R3: While `hold_oe` is 1 and the block does not own the bus, an `ack_in` of 1 sets `grant` one clock later. `ack_out` stays 0 for as long as the block requests or owns the bus.
- R4: When ownership is taken, `burst_len` captures the smaller of `pend_cnt` and `MAX_BURST` (4 by default).
- R5: `grant` and `hold_oe` stay 1 until the `burst_len`-th `cyc_done` pulse while `grant` is 1. Both fall one clock after that pulse.
- R6: When the block is neither requesting nor owning the bus, `ack_out` equals `ack_in` delayed by exactly one clock. This also holds after the block's own burst has finished.
- R7: After a completed burst, `hold_oe` stays 0 while `ack_in` remains 1, even if accesses are still pending. `hold_oe` rises again no sooner than two clocks after `ack_in` is seen low.
- R8: A pending request that appears while an acknowledge is already passing through an idle block does not raise `hold_oe`.
- R9: If `ack_in` falls while the block owns the bus, `grant` and `hold_oe` are 0 one clock later.
- R10: If `pend_cnt` is 0 when acknowledge arrives for a pending request, the block never asserts `grant`. It drops `hold_oe` and forwards acknowledge as after a burst.
- R11: In a cascade of four blocks, each device performs min(pending, 4) cycles per tenure, and a tenure carries at most 16 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_cnt | input | PEND_W (4) | Number of memory accesses waiting in the cycle engine |
| cyc_done | input | 1 | One-cycle pulse from the cycle engine for each completed memory cycle |
| ack_in | input | 1 | Hold acknowledge from upstream (the bus owner or the previous device) |
| hold_oe | output | 1 | Enable for this device's drive onto the shared wired-OR hold line |
| grant | output | 1 | Bus owned; the cycle engine may run cycles |
| burst_len | output | LEN_W (3) | Cycles allowed in the current tenure |
| ack_out | output | 1 | Hold acknowledge passed to the next device |

## Verification
The directed tests go after the boundaries of the burst.
- Request fewer cycles than the limit, then more than it. A design with an off-by-one counter would hold the bus one cycle too long or drop it one cycle early. A design without the clip would let a device exceed its share.
- Keep work pending after a burst while acknowledge stays high. A design that ignored the fairness rule would raise hold again at once and take the bus back.
- Make a request appear while acknowledge is already passing through. A design that took the bus mid-tenure would break the chain.
- Withdraw acknowledge during ownership, and request with zero pending. These expose a design that hangs in ownership or grants a burst of zero.
- Measure the exact forwarding delay. A wrong delay shifts every downstream device.

A four-device cascade then measures the cycles per device in each tenure and confirms that no device requests again before its acknowledge falls.

// File: rtl/hca_pkg.sv
package hca_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_OWN  = 2'd2,
      ST_DONE = 2'd3
   } arb_st_e;

   function automatic logic fwd_allowed(arb_st_e st);
      return (st == ST_IDLE) || (st == ST_DONE);
   endfunction

endpackage

// File: rtl/hca_burst_ctr.sv
module hca_burst_ctr #(
   parameter int MAX_BURST = 4,
   parameter int PEND_W    = 4,
   localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PEND_W-1:0] pend_cnt,
   input  logic              step,
   output logic [LEN_W-1:0]  len_q,
   output logic              zero_len,
   output logic              last
);

   logic [31:0]      pend_ext;
   logic [LEN_W-1:0] clipped;
   logic [LEN_W-1:0] cnt;

   assign pend_ext = 32'(pend_cnt);
   assign clipped  = LEN_W'((pend_ext > 32'(MAX_BURST)) ? 32'(MAX_BURST) : pend_ext);
   assign zero_len = (pend_cnt == '0);
   assign last     = step && (cnt == (len_q - LEN_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         cnt   <= '0;
      end else if (load) begin
         len_q <= clipped;
         cnt   <= '0;
      end else if (step && !last) begin
         cnt   <= cnt + LEN_W'(1);
      end
   end

   // R5
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (cnt < len_q));

   // R4
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= LEN_W'(MAX_BURST));

endmodule

// File: rtl/hca_ack_fwd.sv
module hca_ack_fwd #(
   parameter bit FWD_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_in,
   input  logic fwd_en,
   output logic ack_out
);

   generate
      if (FWD_REG) begin : g_reg
         logic fwd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fwd_q <= 1'b0;
            else        fwd_q <= ack_in && fwd_en;
         end
         assign ack_out = fwd_q;

         // R6
         fwd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ack_out |-> $past(ack_in));
      end else begin : g_comb
         assign ack_out = ack_in && fwd_en;
      end
   endgenerate

endmodule

// File: rtl/hca_fsm.sv
module hca_fsm
   import hca_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    pend_any,
   input  logic    ack_in,
   input  logic    zero_len,
   input  logic    last,
   output arb_st_e st,
   output logic    load
);

   arb_st_e nxt;

   always_comb begin
      nxt  = st;
      load = 1'b0;
      case (st)
         ST_IDLE: if (pend_any && !ack_in) nxt = ST_REQ;
         ST_REQ:  if (ack_in) begin
                     if (zero_len) nxt = ST_DONE;
                     else begin
                        nxt  = ST_OWN;
                        load = 1'b1;
                     end
                  end
         ST_OWN:  if (!ack_in)  nxt = ST_IDLE;
                  else if (last) nxt = ST_DONE;
         ST_DONE: if (!ack_in)  nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nxt;
   end

   // R7
   done_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE && ack_in) |=> (st == ST_DONE));

   // R3
   own_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OWN) |-> $past(ack_in));

endmodule

// File: rtl/hold_chain_arb.sv
module hold_chain_arb
   import hca_pkg::*;
#(
   parameter int MAX_BURST = 4,
   parameter int PEND_W    = 4,
   parameter bit FWD_REG   = 1'b1,
   localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PEND_W-1:0] pend_cnt,
   input  logic              cyc_done,
   input  logic              ack_in,
   output logic              hold_oe,
   output logic              grant,
   output logic [LEN_W-1:0]  burst_len,
   output logic              ack_out
);

   if (MAX_BURST < 1) begin : g_bad_burst
      $error("MAX_BURST must be at least 1");
   end
   if (PEND_W < 1) begin : g_bad_pend
      $error("PEND_W must be at least 1");
   end

   arb_st_e st;
   logic    load;
   logic    zero_len;
   logic    last;
   logic    step;

   assign step = cyc_done && (st == ST_OWN);

   hca_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_any (pend_cnt != '0),
      .ack_in   (ack_in),
      .zero_len (zero_len),
      .last     (last),
      .st       (st),
      .load     (load)
   );

   hca_burst_ctr #(.MAX_BURST(MAX_BURST), .PEND_W(PEND_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .pend_cnt (pend_cnt),
      .step     (step),
      .len_q    (burst_len),
      .zero_len (zero_len),
      .last     (last)
   );

   hca_ack_fwd #(.FWD_REG(FWD_REG)) u_fwd (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_in  (ack_in),
      .fwd_en  (fwd_allowed(st)),
      .ack_out (ack_out)
   );

   assign hold_oe = (st == ST_REQ) || (st == ST_OWN);
   assign grant   = (st == ST_OWN);

   // R3
   fwd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_oe |-> !ack_out);

   // R7
   req_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_oe) |-> !$past(ack_in));

   // R5
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(grant) && ack_in) |-> !hold_oe);

endmodule

// File: tb/test_hold_chain_arb.sv
module test_hold_chain_arb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pend_cnt = '0;
   logic       cyc_done = 1'b0;
   logic       ack_in = 1'b0;
   logic       hold_oe, grant, ack_out;
   logic [2:0] burst_len;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   hold_chain_arb i_hold_chain_arb (
      .clk(clk), .rst_n(rst_n), .pend_cnt(pend_cnt), .cyc_done(cyc_done),
      .ack_in(ack_in), .hold_oe(hold_oe), .grant(grant),
      .burst_len(burst_len), .ack_out(ack_out)
   );

   // four-device cascade
   logic [3:0] hold_c, grant_c, done_c, ack_c, ackin_c;
   logic [3:0] pend_c [4];
   logic [3:0] init_c [4];
   logic [2:0] blen_c [4];
   logic       ack0;
   logic       ld = 1'b0;

   for (genvar g = 0; g < 4; g++) begin : g_chain
      assign ackin_c[g] = (g == 0) ? ack0 : ack_c[(g == 0) ? 0 : g-1];
      hold_chain_arb u_dev (
         .clk(clk), .rst_n(rst_n), .pend_cnt(pend_c[g]), .cyc_done(done_c[g]),
         .ack_in(ackin_c[g]), .hold_oe(hold_c[g]), .grant(grant_c[g]),
         .burst_len(blen_c[g]), .ack_out(ack_c[g])
      );
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done_c[g] <= 1'b0;
            pend_c[g] <= '0;
         end else begin
            done_c[g] <= grant_c[g] && !done_c[g];
            pend_c[g] <= ld ? init_c[g] : pend_c[g] - {3'b0, done_c[g]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack0 <= 1'b0;
      else        ack0 <= |hold_c;
   end

   task automatic chk(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // R7: fairness monitor on the cascade
   logic [3:0] hold_p = '0, ackin_p = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 4; i++) begin
            if (hold_c[i] && !hold_p[i] && ackin_p[i]) begin
               n_bad++;
               $display("FAIL R7: device %0d raised hold (got 1 expected 0) while ack high", i);
            end
         end
      end
      hold_p  = hold_c;
      ackin_p = ackin_c;
   end

   task automatic t_reset();
      tick();
      chk("R1 hold_oe in reset", hold_oe, 0);
      chk("R1 grant in reset", grant, 0);
      chk("R1 ack_out in reset", ack_out, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 hold_oe after reset", hold_oe, 0);
   endtask

   task automatic t_short_burst();
      pend_cnt = 4'd3;
      tick();
      chk("R2 hold raised", hold_oe, 1);
      chk("R2 no grant yet", grant, 0);
      ack_in = 1'b1;
      tick();
      chk("R3 grant", grant, 1);
      chk("R3 ack_out blocked", ack_out, 0);
      chk("R4 burst_len=3", burst_len, 3);
      for (int k = 0; k < 3; k++) begin
         cyc_done = 1'b1;
         tick();
         cyc_done = 1'b0;
         if (k < 2) begin
            chk("R5 grant held mid-burst", grant, 1);
            chk("R3 ack_out blocked mid-burst", ack_out, 0);
            tick();
         end
      end
      chk("R5 grant released", grant, 0);
      chk("R5 hold released", hold_oe, 0);
      chk("R3 ack_out still 0", ack_out, 0);
      tick();
      chk("R6 forwarded after burst", ack_out, 1);
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R7 no rerequest while ack high", hold_oe, 0);
      end
      ack_in = 1'b0;
      tick();
      chk("R7 still quiet at drop edge", hold_oe, 0);
      chk("R6 ack_out follows drop", ack_out, 0);
      tick();
      chk("R7 rerequest after drop", hold_oe, 1);
      ack_in = 1'b1;
      tick();
      chk("R3 grant again", grant, 1);
      ack_in = 1'b0;
      tick();
      chk("R9 grant dropped on abort", grant, 0);
      chk("R9 hold dropped on abort", hold_oe, 0);
      pend_cnt = '0;
      tick();
      tick();
   endtask

   task automatic t_clipped_burst();
      pend_cnt = 4'd9;
      tick();
      ack_in = 1'b1;
      tick();
      chk("R4 burst_len clipped to 4", burst_len, 4);
      for (int k = 0; k < 4; k++) begin
         chk("R5 grant before final cycle", grant, 1);
         cyc_done = 1'b1;
         tick();
         cyc_done = 1'b0;
         tick();
      end
      chk("R5 grant after 4th cycle", grant, 0);
      ack_in   = 1'b0;
      pend_cnt = '0;
      tick();
      tick();
   endtask

   task automatic t_passthrough();
      chk("R6 ack_out before forward", ack_out, 0);
      ack_in = 1'b1;
      tick();
      chk("R6 ack_out one clock later", ack_out, 1);
      pend_cnt = 4'd2;
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R8 no hold mid-pass", hold_oe, 0);
         chk("R8 ack still forwarded", ack_out, 1);
      end
      ack_in = 1'b0;
      tick();
      chk("R6 ack_out drop", ack_out, 0);
      tick();
      chk("R2 hold after pass ends", hold_oe, 1);
      pend_cnt = '0;
      ack_in   = 1'b1;
      tick();
      chk("R10 no grant with zero pending", grant, 0);
      chk("R10 hold dropped", hold_oe, 0);
      tick();
      chk("R10 ack forwarded", ack_out, 1);
      ack_in = 1'b0;
      tick();
      tick();
   endtask

   task automatic t_tenure(string tag, int e0, int e1, int e2, int e3);
      int cnt [4];
      int exp [4];
      int sum;
      int guard;
      exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
      for (int i = 0; i < 4; i++) cnt[i] = 0;
      guard = 0;
      while (!ack0 && guard < 200) begin
         tick();
         guard++;
      end
      while (ack0 && guard < 400) begin
         for (int i = 0; i < 4; i++) cnt[i] += int'(done_c[i]);
         tick();
         guard++;
      end
      sum = 0;
      for (int i = 0; i < 4; i++) begin
         chk({"R11 per-device cycles ", tag}, cnt[i], exp[i]);
         sum += cnt[i];
      end
      chk({"R11 cycles per tenure ", tag}, sum, e0 + e1 + e2 + e3);
   endtask

   task automatic t_chain();
      init_c[0] = 4'd6; init_c[1] = 4'd2; init_c[2] = 4'd4; init_c[3] = 4'd1;
      ld = 1'b1;
      tick();
      ld = 1'b0;
      t_tenure("first", 4, 2, 4, 1);
      t_tenure("leftover", 2, 0, 0, 0);
      while (ack0) tick();
      repeat (4) tick();
      for (int i = 0; i < 4; i++) init_c[i] = 4'd9;
      ld = 1'b1;
      tick();
      ld = 1'b0;
      t_tenure("full", 4, 4, 4, 4);
   endtask

   initial begin
      t_reset();
      t_short_burst();
      t_clipped_burst();
      t_passthrough();
      t_chain();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule